// File: doc/BRIEF.md
# Prescaled 8-bit Clear-on-Compare Timer

An 8-bit up-counter driven by a selectable clock divider. The host picks a division factor, a counting mode and a compare value through register-style inputs. In free-running mode the count sweeps 0x00 to 0xFF and wraps. In clear-on-compare mode it returns to zero after it reaches the compare value, so that value sets the period.

Each compare match raises a sticky flag and can invert a waveform output. This gives a square wave whose half period is N·(1+TOP) input clocks. A separate sticky flag records each wrap from 0xFF to 0x00. The compare value has no shadow register. A new TOP written below the current count is therefore passed over: no match occurs until the count wraps through 0xFF. The host can preload the count through a synchronous write port.

Top module: `timer8_ctc`

## Requirements
- R1: While rst_n is low, count, cmp_flag, ovf_flag and wave_out are all 0.
- R2: clk_sel=0 stops the counter. clk_sel values 1..7 select the divide factors N=1, 8, 32, 64, 128, 256 and 1024, in that order. The counter takes one step every N clocks.
- R3: With mode_sel other than 2, the counter counts freely and goes from 0xFF to 0x00.
- R4: With mode_sel=2, a tick that finds count equal to top_val loads 0 into the count.
- R5: top_val acts at once, with no buffering. If it is below the count, the counter runs up to 0xFF, wraps to 0x00 and only then reaches the new value.
- R6: cmp_flag sets on every tick where count equals top_val, in any mode. It holds until a cycle with flag_clr[0]=1. A set in the same cycle as a clear wins.
- R7: ovf_flag sets on every tick where count is 0xFF. It holds until a cycle with flag_clr[1]=1. A set in the same cycle as a clear wins.
- R8: With out_mode=1, wave_out inverts on each compare match. Any other out_mode value holds wave_out at its level.
- R9: In clear-on-compare mode with toggling, wave_out changes every N·(1+TOP) clocks. With TOP=0 and N=1 it changes every clock.
- R10: cnt_wr=1 loads cnt_wdata into count at the next edge, overriding any tick. In that cycle the write suppresses both the compare match and the overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Counting mode; 2 = clear on compare, others = free run |
| out_mode | input | 2 | Output action; 1 = toggle on match, others = hold |
| clk_sel | input | 3 | Divider select; 0 = stopped |
| top_val | input | 8 | Compare value |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Count write value |
| flag_clr | input | 2 | Write-one-to-clear; bit 0 cmp_flag, bit 1 ovf_flag |
| count | output | 8 | Current count |
| cmp_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| wave_out | output | 1 | Waveform output |

## Verification
The per-tick increment and clear properties are checked only under clk_sel=1. At that setting every clock is a tick, so those properties need no knowledge of the divider phase. The slower divide factors are checked in the bench by measuring the interval between output toggles. The properties also take top_val to be steady while they are checked. The bench changes top_val, clk_sel and mode_sel only while the divider is stopped, or with the counter set by a count write. A fresh setting is therefore never matched against a stale one partway through a property.

// File: rtl/timer8_ctc.sv
module timer8_ctc #(
  parameter int W  = 8,
  parameter int PW = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_sel,
  input  logic [1:0]   out_mode,
  input  logic [2:0]   clk_sel,
  input  logic [W-1:0] top_val,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic [1:0]   flag_clr,
  output logic [W-1:0] count,
  output logic         cmp_flag,
  output logic         ovf_flag,
  output logic         wave_out
);
  localparam logic [W-1:0] MAXV = '1;

  logic [PW-1:0] pre;
  logic tick, hit, wrap, ctc_clr;

  always_comb begin
    case (clk_sel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &pre[2:0];
      3'd3:    tick = &pre[4:0];
      3'd4:    tick = &pre[5:0];
      3'd5:    tick = &pre[6:0];
      3'd6:    tick = &pre[7:0];
      3'd7:    tick = &pre[9:0];
      default: tick = 1'b0;
    endcase
  end

  assign hit     = tick && !cnt_wr && (count == top_val);
  assign wrap    = tick && !cnt_wr && (count == MAXV);
  assign ctc_clr = hit && (mode_sel == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre      <= '0;
      count    <= '0;
      cmp_flag <= 1'b0;
      ovf_flag <= 1'b0;
      wave_out <= 1'b0;
    end else begin
      pre <= pre + 1'b1;
      if (cnt_wr)       count <= cnt_wdata;
      else if (ctc_clr) count <= '0;
      else if (tick)    count <= count + 1'b1;
      cmp_flag <= hit  | (cmp_flag & ~flag_clr[0]);
      ovf_flag <= wrap | (ovf_flag & ~flag_clr[1]);
      if (hit && out_mode == 2'd1) wave_out <= ~wave_out;
    end
  end
endmodule

// File: rtl/timer8_ctc_chk.sv
module timer8_ctc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic [1:0] out_mode,
  input logic [2:0] clk_sel,
  input logic [7:0] top_val,
  input logic       cnt_wr,
  input logic [7:0] cnt_wdata,
  input logic [1:0] flag_clr,
  input logic [7:0] count,
  input logic       cmp_flag,
  input logic       wave_out
);
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0 && !cnt_wr) |=> count == $past(count)); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd1 && !cnt_wr && count != top_val && count != 8'hFF)
      |=> count == 8'($past(count) + 8'd1)); // R3

  AST_CTC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd2 && clk_sel == 3'd1 && !cnt_wr && count == top_val)
      |=> (count == 8'd0 && cmp_flag)); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag && !flag_clr[0]) |=> cmp_flag); // R6

  AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode != 2'd1) |=> wave_out == $past(wave_out)); // R8

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(cnt_wdata)); // R10
endmodule

bind timer8_ctc timer8_ctc_chk u_chk (.*);

// File: tb/tb_timer8_ctc.sv
module tb_timer8_ctc;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode_sel = 0, out_mode = 0, flag_clr = 0;
  logic [2:0] clk_sel = 0;
  logic [7:0] top_val = 0, cnt_wdata = 0;
  logic cnt_wr = 0;
  logic [7:0] count;
  logic cmp_flag, ovf_flag, wave_out;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  timer8_ctc dut (.*);

  // {clk_sel, top_val, expected clocks between toggles}
  localparam logic [21:0] VEC [8] = '{
    {3'd1, 8'd0, 11'd1},   {3'd1, 8'd3, 11'd4},
    {3'd2, 8'd1, 11'd16},  {3'd3, 8'd2, 11'd96},
    {3'd4, 8'd0, 11'd64},  {3'd5, 8'd1, 11'd256},
    {3'd6, 8'd0, 11'd256}, {3'd7, 8'd0, 11'd1024}};

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic half_period(output int n);
    logic prev;
    prev = wave_out; n = 0;
    while (wave_out == prev && n < 5000) begin @(negedge clk); n++; end
    prev = wave_out; n = 0;
    while (wave_out == prev && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic load(input logic [7:0] v);
    cnt_wr = 1; cnt_wdata = v; flag_clr = 2'b11;
    tick(1);
    cnt_wr = 0; flag_clr = 0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog R1..all actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int hp;
    logic w;
    tick(3);
    check("R1 count", count, 0);
    check("R1 flags", {cmp_flag, ovf_flag}, 0);
    check("R1 wave", wave_out, 0);
    rst_n = 1;

    tick(20);
    check("R2 stopped", count, 0);

    mode_sel = 2; out_mode = 1;
    foreach (VEC[i]) begin
      clk_sel = VEC[i][21:19]; top_val = VEC[i][18:11];
      load(8'd0);
      half_period(hp);
      check($sformatf("R9 R2 vec%0d", i), hp, int'(VEC[i][10:0]));
    end

    // R3 free run wrap
    clk_sel = 0; mode_sel = 0; top_val = 8'h80;
    load(8'hFD);
    clk_sel = 1;
    check("R3 loaded", count, 8'hFD);
    tick(3);
    check("R3 wrap", count, 0);
    check("R7 ovf set", ovf_flag, 1);
    clk_sel = 0; flag_clr = 2'b10; tick(1); flag_clr = 0;
    check("R7 ovf cleared", ovf_flag, 0);

    // R4/R5 top below count
    mode_sel = 2; top_val = 8'd10; clk_sel = 1;
    load(8'd20);
    check("R5 start", count, 20);
    tick(235);
    check("R5 reaches FF", count, 8'hFF);
    check("R5 no early match", cmp_flag, 0);
    tick(1);
    check("R5 wrapped", count, 0);
    check("R7 ovf on wrap", ovf_flag, 1);
    tick(10);
    check("R4 at top", count, 10);
    check("R6 not yet", cmp_flag, 0);
    tick(1);
    check("R4 cleared", count, 0);
    check("R6 set on match", cmp_flag, 1);

    // R6 set wins over clear, then clear
    top_val = 0; load(8'd0); clk_sel = 1;
    tick(1);
    flag_clr = 2'b01; tick(1);
    check("R6 set beats clear", cmp_flag, 1);
    clk_sel = 0; tick(1); flag_clr = 0;
    check("R6 cleared", cmp_flag, 0);

    // R8 hold
    out_mode = 0; clk_sel = 1; w = wave_out;
    tick(10);
    check("R8 hold", wave_out, w);
    out_mode = 1; w = wave_out; tick(1);
    check("R8 toggle", wave_out, !w);

    // R10 write suppresses match and overflow
    clk_sel = 0; top_val = 5; load(8'd5);
    clk_sel = 1; cnt_wr = 1; cnt_wdata = 9; tick(1); cnt_wr = 0;
    check("R10 count", count, 9);
    check("R10 no match", cmp_flag, 0);
    clk_sel = 0; load(8'hFF);
    clk_sel = 1; cnt_wr = 1; cnt_wdata = 3; tick(1); cnt_wr = 0; clk_sel = 0;
    check("R10 count2", count, 3);
    check("R10 no ovf", ovf_flag, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule